// File: doc/BRIEF.md
# JTAG debug command controller

This block is the test-port front end of a processor debug unit. A standard 16-state TAP state machine runs on the test clock. The instruction register serves as a debug command register. The command it holds picks which debug resource sits between the serial data input and the serial data output during the data-register scan. Some commands act at the moment they are updated. These are the commands that raise and drop the halt request to the core and the one that clears the error flag.

Resources fall into three classes. Some are always open: the bypass bit, the status word and a free scratch register. One is guarded: a register that may be read while the core runs, but only written while the core is halted. The last is the CPU scan chain, which is only connected once the synchronized halt indication is seen. A write to a guarded resource while the core runs is dropped and sets a sticky error bit. Debug software reads that bit from the status word. Debug software polls the status word to learn whether the core has halted before it touches a guarded resource.

Top module: `dbg_tap_ctrl`

## Requirements
- R1: While rst_ni is low, dbg_req_o, tdo_o, tdo_en_o, scan_shift_o and scan_exec_o are 0, and the command register holds bypass (4'hF).
- R2: From any state, five rising edges of tck_i with tms_i high bring the state machine to Test-Logic-Reset. Test-Logic-Reset reloads the command register with bypass (4'hF) and clears dbg_req_o.
- R3: Capture-IR loads 4'b0001. In Shift-IR the command register shifts least significant bit first, with tdi_i entering at bit 3. The new 4-bit command takes effect at Update-IR.
- R4: tdo_o and tdo_en_o change on the falling edge of tck_i. tdo_en_o is 1 only in Shift-IR and Shift-DR, and tdo_o is 0 in every other state.
- R5: Updating command 4'h2 sets dbg_req_o. It stays set through other commands until command 4'h3 is updated or Test-Logic-Reset is entered.
- R6: Command 4'h1 selects a 4-bit read-only status word, shifted out least significant bit first: bit0 is halted_i after two tck_i flops, bit1 is dbg_req_o, bit2 is the sticky error, bit3 is 0.
- R7: Commands 4'h0, 4'h2, 4'h3, 4'h8 and 4'h9 to 4'hF select a 1-bit bypass register that captures 0. A bit shifted in appears on tdo_o one shift later.
- R8: Command 4'h6 selects a 16-bit scratch register. Its value is captured and its new value is written at Update-DR whether or not the core is halted.
- R9: Command 4'h4 reads the 16-bit guarded register at any time. Its Update-DR never changes that register.
- R10: Command 4'h5 writes the guarded register at Update-DR only when the synchronized halt bit is 1. Otherwise the write is dropped and the sticky error bit is set.
- R11: Command 4'h7 behaves as follows when the synchronized halt bit is 1: scan_shift_o is high in each Shift-DR cycle, scan_tdi_o follows tdi_i, tdo_o carries scan_tdo_i, and scan_exec_o is high for the Update-DR cycle. When the bit is 0, scan_shift_o and scan_exec_o stay 0, the path acts as a 1-bit bypass, and Update-DR sets the sticky error bit.
- R12: Updating command 4'h8 clears the sticky error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select, sampled on rising tck_i |
| tdi_i | input | 1 | Serial data in, sampled on rising tck_i |
| tdo_o | output | 1 | Serial data out, changes on falling tck_i |
| tdo_en_o | output | 1 | High while tdo_o carries shift data |
| halted_i | input | 1 | Core halted indication, asynchronous to tck_i |
| dbg_req_o | output | 1 | Debug (halt) request to the core |
| scan_shift_o | output | 1 | Shift enable for the CPU scan chain |
| scan_tdi_o | output | 1 | Serial data into the CPU scan chain |
| scan_tdo_i | input | 1 | Serial data out of the CPU scan chain |
| scan_exec_o | output | 1 | One-cycle execute strobe for the scanned instruction |

## Verification
The assertions assume that tms_i and tdi_i are stable at each rising edge of tck_i. They do not assume that halted_i is synchronous, because every rule about it is checked against the synchronized copy. The bench changes tms_i, tdi_i and halted_i just after a falling edge, so they are settled well before the next rising edge. It changes halted_i only outside scans, except in the two directed cases that measure the two-flop latency one edge apart. The random TMS walks may pass through any Update state with random shifted data. Because of that, the bench checks after such a walk only what R2 promises: the halt request and the bypass path.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int unsigned CMD_W  = 4;
  localparam int unsigned STAT_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    SEL_BYP, SEL_STAT, SEL_GRD_RD, SEL_GRD_WR, SEL_FREE, SEL_SCAN
  } dr_sel_e;

  localparam logic [CMD_W-1:0] CMD_STATUS  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_HALT    = 4'h2;
  localparam logic [CMD_W-1:0] CMD_RELEASE = 4'h3;
  localparam logic [CMD_W-1:0] CMD_GRD_RD  = 4'h4;
  localparam logic [CMD_W-1:0] CMD_GRD_WR  = 4'h5;
  localparam logic [CMD_W-1:0] CMD_FREE    = 4'h6;
  localparam logic [CMD_W-1:0] CMD_SCAN    = 4'h7;
  localparam logic [CMD_W-1:0] CMD_CLR_ERR = 4'h8;
  localparam logic [CMD_W-1:0] CMD_BYPASS  = 4'hF;

  function automatic dr_sel_e decode_cmd(logic [CMD_W-1:0] cmd);
    case (cmd)
      CMD_STATUS: return SEL_STAT;
      CMD_GRD_RD: return SEL_GRD_RD;
      CMD_GRD_WR: return SEL_GRD_WR;
      CMD_FREE:   return SEL_FREE;
      CMD_SCAN:   return SEL_SCAN;
      default:    return SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // run length of consecutive TMS-high edges, saturating at 5
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         ones_q <= '0;
    else if (!tms_i)     ones_q <= '0;
    else if (ones_q < 5) ones_q <= ones_q + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q >= 3'd5) |-> (state_q == TLR));

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  tap_state_e       state_i,
  input  logic             tdi_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [CMD_W-1:0] cmd_shift_o,
  output logic             ir_tdo_o
);

  logic [CMD_W-1:0] sh_q, cmd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (state_i == CAP_IR) begin
      sh_q <= CMD_W'(1);
    end else if (state_i == SH_IR) begin
      sh_q <= {tdi_i, sh_q[CMD_W-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 cmd_q <= CMD_BYPASS;
    else if (state_i == TLR)     cmd_q <= CMD_BYPASS;
    else if (state_i == UPD_IR)  cmd_q <= sh_q;
  end

  assign cmd_o       = cmd_q;
  assign cmd_shift_o = sh_q;
  assign ir_tdo_o    = sh_q[0];

  assert_tlr_bypass_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == TLR) |=> (cmd_q == CMD_BYPASS));

  assert_cmd_only_at_update_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(cmd_q) |-> $past(state_i == UPD_IR || state_i == TLR));

endmodule

// File: rtl/dbg_tap_sync.sv
module dbg_tap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
  import dbg_tap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  dr_sel_e    sel_i,
  input  logic       tdi_i,
  input  logic       halt_s_i,
  input  logic       dbg_req_i,
  input  logic       clr_err_i,
  output logic       dr_tdo_o,
  output logic       err_o,
  output logic       scan_live_o,
  output logic       scan_shift_o,
  output logic       scan_exec_o
);

  logic [DATA_W-1:0] dr_q, sh_next, cap_val, guard_q, free_q;
  logic              err_q, upd, scan_live;
  int                len;

  assign scan_live = (sel_i == SEL_SCAN) && halt_s_i;
  assign upd       = (state_i == UPD_DR);

  always_comb begin
    case (sel_i)
      SEL_STAT:                       len = int'(STAT_W);
      SEL_GRD_RD, SEL_GRD_WR, SEL_FREE: len = int'(DATA_W);
      default:                        len = 1;
    endcase
  end

  always_comb begin
    case (sel_i)
      SEL_STAT:               cap_val = DATA_W'({1'b0, err_q, dbg_req_i, halt_s_i});
      SEL_GRD_RD, SEL_GRD_WR: cap_val = guard_q;
      SEL_FREE:               cap_val = free_q;
      default:                cap_val = '0;
    endcase
  end

  // tdi enters at the top bit of the selected length
  generate
    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_shift
      if (i < int'(DATA_W) - 1) begin : g_mid
        assign sh_next[i] = (i == len - 1) ? tdi_i : ((i < len - 1) ? dr_q[i+1] : 1'b0);
      end else begin : g_top
        assign sh_next[i] = (i == len - 1) ? tdi_i : 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                dr_q <= '0;
    else if (state_i == CAP_DR) dr_q <= cap_val;
    else if (state_i == SH_DR)  dr_q <= sh_next;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                      guard_q <= '0;
    else if (upd && sel_i == SEL_GRD_WR && halt_s_i)  guard_q <= dr_q;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                        free_q <= '0;
    else if (upd && sel_i == SEL_FREE)  free_q <= dr_q;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (clr_err_i) begin
      err_q <= 1'b0;
    end else if (upd && !halt_s_i && (sel_i == SEL_GRD_WR || sel_i == SEL_SCAN)) begin
      err_q <= 1'b1;
    end
  end

  assign dr_tdo_o     = dr_q[0];
  assign err_o        = err_q;
  assign scan_live_o  = scan_live;
  assign scan_shift_o = scan_live && (state_i == SH_DR);
  assign scan_exec_o  = scan_live && upd;

  assert_guard_needs_halt_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(guard_q) |-> $past(upd && sel_i == SEL_GRD_WR && halt_s_i));

  assert_err_from_update_R11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(state_i == UPD_DR));

  assert_free_only_own_cmd_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(free_q) |-> $past(upd && sel_i == SEL_FREE));

endmodule

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
  import dbg_tap_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_en_o,
  input  logic halted_i,
  output logic dbg_req_o,
  output logic scan_shift_o,
  output logic scan_tdi_o,
  input  logic scan_tdo_i,
  output logic scan_exec_o
);

  tap_state_e       state;
  logic [CMD_W-1:0] cmd, cmd_shift;
  logic             ir_tdo, dr_tdo, halt_s, err, scan_live;
  logic             dbg_req_q, tdo_q, tdo_en_q, cmd_upd, clr_err;
  dr_sel_e          sel;

  dbg_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  dbg_tap_ir u_ir (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .tdi_i       (tdi_i),
    .cmd_o       (cmd),
    .cmd_shift_o (cmd_shift),
    .ir_tdo_o    (ir_tdo)
  );

  dbg_tap_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .d_i    (halted_i),
    .q_o    (halt_s)
  );

  assign sel     = decode_cmd(cmd);
  assign cmd_upd = (state == UPD_IR);
  assign clr_err = cmd_upd && (cmd_shift == CMD_CLR_ERR);

  dbg_tap_dr #(.DATA_W(DATA_W)) u_dr (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .sel_i        (sel),
    .tdi_i        (tdi_i),
    .halt_s_i     (halt_s),
    .dbg_req_i    (dbg_req_q),
    .clr_err_i    (clr_err),
    .dr_tdo_o     (dr_tdo),
    .err_o        (err),
    .scan_live_o  (scan_live),
    .scan_shift_o (scan_shift_o),
    .scan_exec_o  (scan_exec_o)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                                    dbg_req_q <= 1'b0;
    else if (state == TLR)                          dbg_req_q <= 1'b0;
    else if (cmd_upd && cmd_shift == CMD_HALT)      dbg_req_q <= 1'b1;
    else if (cmd_upd && cmd_shift == CMD_RELEASE)   dbg_req_q <= 1'b0;
  end

  // output stage on falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR)      tdo_q <= ir_tdo;
      else if (state == SH_DR) tdo_q <= scan_live ? scan_tdo_i : dr_tdo;
      else                     tdo_q <= 1'b0;
    end
  end

  assign tdo_o      = tdo_q;
  assign tdo_en_o   = tdo_en_q;
  assign dbg_req_o  = dbg_req_q;
  assign scan_tdi_o = tdi_i;

  assert_req_from_update_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(dbg_req_q) |-> $past(state == UPD_IR));

  assert_tdo_en_shift_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_q == ((state == SH_IR) || (state == SH_DR)));

  assert_tdo_quiet_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_q |-> !tdo_q);

  assert_err_seen_R12: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clr_err |=> !err);

endmodule

// File: tb/dbg_tap_ctrl_test.sv
`timescale 1ns/1ps
module dbg_tap_ctrl_test;

  localparam logic [3:0] C_STATUS  = 4'h1;
  localparam logic [3:0] C_HALT    = 4'h2;
  localparam logic [3:0] C_RELEASE = 4'h3;
  localparam logic [3:0] C_GRD_RD  = 4'h4;
  localparam logic [3:0] C_GRD_WR  = 4'h5;
  localparam logic [3:0] C_FREE    = 4'h6;
  localparam logic [3:0] C_SCAN    = 4'h7;
  localparam logic [3:0] C_CLR_ERR = 4'h8;
  localparam logic [3:0] C_BYPASS  = 4'hF;

  logic tck = 1'b0;
  logic rst_n, tms_r, tdi_r, halted_r;
  logic tdo_o, tdo_en_o, dbg_req_o, scan_shift_o, scan_tdi_o, scan_exec_o;
  logic [7:0] chain_q;
  int checks = 0;
  int failures = 0;
  int exec_cnt = 0;
  int shift_cnt = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  dbg_tap_ctrl uut (
    .tck_i        (tck),
    .rst_ni       (rst_n),
    .tms_i        (tms_r),
    .tdi_i        (tdi_r),
    .tdo_o        (tdo_o),
    .tdo_en_o     (tdo_en_o),
    .halted_i     (halted_r),
    .dbg_req_o    (dbg_req_o),
    .scan_shift_o (scan_shift_o),
    .scan_tdi_o   (scan_tdi_o),
    .scan_tdo_i   (chain_q[0]),
    .scan_exec_o  (scan_exec_o)
  );

  // model of the CPU scan chain
  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) chain_q <= 8'hA5;
    else if (scan_shift_o) chain_q <= {scan_tdi_o, chain_q[7:1]};
  end

  always @(posedge tck) begin
    if (scan_exec_o)  exec_cnt <= exec_cnt + 1;
    if (scan_shift_o) shift_cnt <= shift_cnt + 1;
  end

  function automatic logic [31:0] exp_status(logic h, logic r, logic e);
    return {28'd0, 1'b0, e, r, h};
  endfunction

  function automatic logic [31:0] exp_bypass(logic [31:0] din, int n);
    logic [31:0] m = (32'h1 << n) - 32'h1;
    return (din << 1) & m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tclk(input logic tms, input logic tdi);
    tms_r = tms;
    tdi_r = tdi;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tclk(1'b0, 1'b0);
  endtask

  task automatic ir_cmd(input logic [3:0] c);
    tclk(1, 0); tclk(1, 0); tclk(0, 0); tclk(0, 0);
    for (int i = 0; i < 4; i++) tclk(i == 3, c[i]);
    tclk(1, 0); tclk(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tclk(i == n - 1, din[i]);
    end
    tclk(1, 0); tclk(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    tclk(1, 0); tclk(0, 0); tclk(0, 0);
    shift_dr(n, din, dout);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (60000) @(posedge tck);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] out, din, prev;
    logic [3:0] got;
    logic h;
    void'($urandom(32'd4711));
    rst_n = 1'b0; tms_r = 1'b1; tdi_r = 1'b0; halted_r = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    check("R1 tdo_en in reset", tdo_en_o, 0);
    check("R1 tdo in reset", tdo_o, 0);
    check("R1 dbg_req in reset", dbg_req_o, 0);
    check("R1 scan strobes in reset", {scan_shift_o, scan_exec_o}, 0);
    rst_n = 1'b1;
    tclk(1, 0);
    tclk(0, 0);

    // R3 / R4: manual walk into Shift-IR
    tclk(1, 0); tclk(1, 0); tclk(0, 0);
    check("R4 tdo_en low in Capture-IR", tdo_en_o, 0);
    tclk(0, 0);
    check("R4 tdo_en high in Shift-IR", tdo_en_o, 1);
    for (int i = 0; i < 4; i++) begin
      got[i] = tdo_o;
      tclk(i == 3, C_BYPASS[i]);
    end
    check("R4 tdo_en low in Exit1-IR", tdo_en_o, 0);
    check("R4 tdo low in Exit1-IR", tdo_o, 0);
    check("R3 capture-IR pattern", got, 4'b0001);
    tclk(1, 0); tclk(0, 0);

    // R1 / R7: bypass after reset
    dr_scan(4, 32'hB, out);
    check("R1 R7 bypass after reset", out, exp_bypass(32'hB, 4));

    // R6 status idle
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R6 status idle", out, exp_status(0, 0, 0));

    // R5 halt request
    ir_cmd(C_HALT);
    check("R5 dbg_req set", dbg_req_o, 1);
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R5 R6 status shows request", out, exp_status(0, 1, 0));

    // R6 two-flop latency: change before the first of three edges is seen
    halted_r = 1'b1;
    dr_scan(4, 0, out);
    check("R6 halt seen after two edges", out, exp_status(1, 1, 0));
    halted_r = 1'b0;
    idle(3);
    tclk(1, 0);
    halted_r = 1'b1;
    tclk(0, 0); tclk(0, 0);
    shift_dr(4, 0, out);
    check("R6 halt not yet seen after one edge", out, exp_status(0, 1, 0));
    idle(3);

    // R10 / R9 guarded register
    ir_cmd(C_GRD_WR);
    dr_scan(16, 32'hBEEF, out);
    check("R10 guarded capture reset value", out, 0);
    ir_cmd(C_GRD_RD);
    dr_scan(16, 32'h1234, out);
    check("R10 halted write landed", out, 32'hBEEF);
    dr_scan(16, 0, out);
    check("R9 read command does not write", out, 32'hBEEF);
    check("R5 request held across commands", dbg_req_o, 1);
    ir_cmd(C_RELEASE);
    check("R5 release clears request", dbg_req_o, 0);
    halted_r = 1'b0;
    idle(3);
    ir_cmd(C_GRD_RD);
    dr_scan(16, 0, out);
    check("R9 read while running", out, 32'hBEEF);
    ir_cmd(C_GRD_WR);
    dr_scan(16, 32'h5555, out);
    ir_cmd(C_GRD_RD);
    dr_scan(16, 0, out);
    check("R10 running write dropped", out, 32'hBEEF);
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R10 sticky error set", out, exp_status(0, 0, 1));
    idle(2);
    dr_scan(4, 0, out);
    check("R10 error stays sticky", out, exp_status(0, 0, 1));
    ir_cmd(C_CLR_ERR);
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R12 error cleared", out, exp_status(0, 0, 0));

    // R8 scratch register, random data and random halt state
    ir_cmd(C_FREE);
    prev = 0;
    for (int it = 0; it < 12; it++) begin
      halted_r = 1'($urandom_range(0, 1));
      idle(3);
      din = {16'd0, 16'($urandom())};
      dr_scan(16, din, out);
      check("R8 scratch readback", out, prev);
      prev = din;
    end
    halted_r = 1'b0;
    idle(3);
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R8 scratch access raises no error", out, exp_status(0, 0, 0));

    // R11 CPU scan chain
    ir_cmd(C_HALT);
    halted_r = 1'b1;
    idle(3);
    ir_cmd(C_SCAN);
    begin
      int e0, s0;
      e0 = exec_cnt; s0 = shift_cnt;
      dr_scan(8, 32'h3C, out);
      check("R11 scan out old chain", out, 32'hA5);
      check("R11 exec strobe once", exec_cnt, e0 + 1);
      check("R11 eight shift cycles", shift_cnt, s0 + 8);
      dr_scan(8, 32'hC7, out);
      check("R11 scan out shifted data", out, 32'h3C);
      halted_r = 1'b0;
      idle(3);
      e0 = exec_cnt; s0 = shift_cnt;
      dr_scan(4, 32'h6, out);
      check("R11 bypass while running", out, exp_bypass(32'h6, 4));
      check("R11 no exec while running", exec_cnt, e0);
      check("R11 no shift while running", shift_cnt, s0);
    end
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R11 error on running scan", out, exp_status(0, 1, 1));
    ir_cmd(C_CLR_ERR);
    ir_cmd(C_RELEASE);
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R12 R5 cleared state", out, exp_status(0, 0, 0));

    // R7 unassigned commands select bypass
    for (int it = 0; it < 8; it++) begin
      logic [3:0] c;
      c = (it == 0) ? 4'h0 : 4'($urandom_range(9, 14));
      ir_cmd(c);
      din = 32'($urandom_range(0, 15));
      dr_scan(4, din, out);
      check("R7 unassigned command bypass", out, exp_bypass(din, 4));
    end

    // R2 random TMS walks then five TMS-high clocks
    for (int it = 0; it < 10; it++) begin
      ir_cmd(C_HALT);
      check("R5 request before walk", dbg_req_o, 1);
      for (int k = 0; k < int'($urandom_range(0, 20)); k++)
        tclk(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      repeat (5) tclk(1, 0);
      tclk(0, 0);
      check("R2 reset clears request", dbg_req_o, 0);
      din = 32'($urandom_range(0, 15));
      dr_scan(4, din, out);
      check("R2 reset restores bypass", out, exp_bypass(din, 4));
    end
    ir_cmd(C_CLR_ERR);
    h = 1'b0;
    ir_cmd(C_STATUS);
    dr_scan(4, 0, out);
    check("R12 final status", out, exp_status(h, 0, 0));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule